// File: doc/BRIEF.md
# Compact Floating-Point Adder

This block adds two signed values held in a compact 18-bit floating-point word. The sign is in bit 17 (0 means positive). The exponent is in bits 16:9 and is stored with an offset of 128, so 128 stands for 2^0. The mantissa is in bits 8:0. It is a fraction whose top bit has weight one half, and it is kept explicit rather than implied. A word whose mantissa top bit is clear counts as zero, whatever its other bits hold. The format has no special values, no denormals and no rounding.

The adder works out which operand has the larger magnitude and shifts the smaller mantissa right to match. It then adds the mantissas when the signs agree or subtracts them when they differ, and renormalizes the result. A leading-zero count sets the left shift after a subtraction in one pass. The sum leaves through a one-cycle output register by default. A parameter removes that register and leaves a purely combinational path.

Top module: `fp18_adder`

## Requirements
- R1: An operand counts as zero exactly when its mantissa bit 8 is 0. When both operands are zero, the output word is all zeros.
- R2: When exactly one operand is zero, the output is the other operand's full 18-bit word, unchanged.
- R3: The operand with the larger magnitude is chosen by comparing the exponents first and then, on an exponent tie, the mantissas. When the signs differ, the result takes the sign of that operand.
- R4: When both operands are nonzero and their exponents differ by more than 8, the output is the larger operand's word, unchanged.
- R5: With equal signs, the mantissas are added after the smaller one is shifted right by the exponent difference. If the sum reaches 1.0, the sum is shifted right by one and the exponent rises by one. The result carries the common sign.
- R6: With differing signs, the result is the larger mantissa minus the aligned smaller mantissa. It is shifted left until bit 8 is set, and the exponent drops by one for each shift.
- R7: When operands with differing signs cancel exactly, the output is all zeros.
- R8: When REG_OUT=1, the output changes only on a rising clock edge, shows the sum of the inputs present at that edge, and is all zeros during reset.
- R9: Every nonzero output word has its mantissa bit 8 set.
- R10: No rounding is performed. Bits shifted out of the smaller mantissa during alignment, and bits shifted out of a carried sum, are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | 18 | First operand {sign, exponent, mantissa} |
| opB | input | 18 | Second operand {sign, exponent, mantissa} |
| sum | output | 18 | Sum word |

## Verification
The main sweep pairs sixteen mantissas spread across the whole normalized range and uses every sign combination. Exponent offsets run from -10 to +10, in both operand orders. This separates carry-out from no-carry additions and shallow from deep renormalization, and it separates the aligned path from the bypass on either side of a gap of 8. Directed words cover zero operands whose other bits are nonzero, an exponent tie decided by the mantissa, exact cancellation, and the maximum eight-place left shift. The expected words come from a real-number model: truncation for like signs and ceiling for unlike signs, applied on the larger operand's grid.

// File: rtl/fp18_pkg.sv
package fp18_pkg;
  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic swapOps;   // opB has the larger magnitude
    logic effSub;    // signs differ: subtract mantissas
    logic passBig;   // exponent gap too wide: output the larger word
    logic zeroOut;   // both operands are zero
    logic passA;     // only opB is zero
    logic passB;     // only opA is zero
  } addCtrl_t;
endpackage

// File: rtl/fp18_add_ctrl.sv
module fp18_add_ctrl
  import fp18_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 9
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  output addCtrl_t             ctrl,
  output logic [EXP_W-1:0]     expGap
);
  localparam int W = EXP_W + MAN_W + 1;

  logic aNz, bNz, bBigger;
  logic [EXP_W-1:0] expA, expB;

  assign aNz  = opA[MAN_W-1];
  assign bNz  = opB[MAN_W-1];
  assign expA = opA[W-2:MAN_W];
  assign expB = opB[W-2:MAN_W];

  // The exponent sits above the mantissa, so one compare of the two fields
  // together orders by exponent first and mantissa second.
  assign bBigger = opB[W-2:0] > opA[W-2:0];
  assign expGap  = bBigger ? (expB - expA) : (expA - expB);

  always_comb begin
    ctrl.swapOps = bBigger;
    ctrl.effSub  = opA[W-1] ^ opB[W-1];
    ctrl.zeroOut = !aNz && !bNz;
    ctrl.passA   = aNz && !bNz;
    ctrl.passB   = !aNz && bNz;
    ctrl.passBig = aNz && bNz && (expGap > EXP_W'(MAN_W - 1));
  end
endmodule

// File: rtl/fp18_add_dpath.sv
module fp18_add_dpath
  import fp18_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 9
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  addCtrl_t             ctrl,
  input  logic [EXP_W-1:0]     expGap,
  output logic [EXP_W+MAN_W:0] res
);
  localparam int W   = EXP_W + MAN_W + 1;
  localparam int LZW = $clog2(MAN_W + 1);

  logic [W-1:0]     bigW, smallW;
  logic             bigSign;
  logic [EXP_W-1:0] bigExp;
  logic [MAN_W-1:0] bigMan, smallMan, aligned, diffMan, subMan, addMan;
  logic [MAN_W:0]   sumExt;
  logic [EXP_W-1:0] subExp, addExp;
  logic [LZW-1:0]   lzCount;

  assign bigW     = ctrl.swapOps ? opB : opA;
  assign smallW   = ctrl.swapOps ? opA : opB;
  assign bigSign  = bigW[W-1];
  assign bigExp   = bigW[W-2:MAN_W];
  assign bigMan   = bigW[MAN_W-1:0];
  assign smallMan = smallW[MAN_W-1:0];

  // Alignment: bits shifted out are dropped.
  assign aligned = smallMan >> expGap;

  // Like-sign path: a carry out means shift right once and bump the exponent.
  assign sumExt = {1'b0, bigMan} + {1'b0, aligned};
  assign addMan = sumExt[MAN_W] ? sumExt[MAN_W:1] : sumExt[MAN_W-1:0];
  assign addExp = bigExp + EXP_W'(sumExt[MAN_W]);

  // Unlike-sign path: leading-zero count and left shift in one pass.
  assign diffMan = bigMan - aligned;

  always_comb begin
    lzCount = LZW'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (diffMan[i]) lzCount = LZW'(MAN_W - 1 - i);
  end

  assign subMan = diffMan << lzCount;
  assign subExp = bigExp - EXP_W'(lzCount);

  always_comb begin
    if (ctrl.zeroOut)       res = '0;
    else if (ctrl.passA)    res = opA;
    else if (ctrl.passB)    res = opB;
    else if (ctrl.passBig)  res = bigW;
    else if (ctrl.effSub)   res = (diffMan == '0) ? '0 : {bigSign, subExp, subMan};
    else                    res = {bigSign, addExp, addMan};
  end
endmodule

// File: rtl/fp18_adder.sv
module fp18_adder
  import fp18_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 9,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [EXP_W+MAN_W:0]   opA,
  input  logic [EXP_W+MAN_W:0]   opB,
  output logic [EXP_W+MAN_W:0]   sum
);
  localparam int W = EXP_W + MAN_W + 1;

  addCtrl_t         ctrl;
  logic [EXP_W-1:0] expGap;
  logic [W-1:0]     sumComb;

  fp18_add_ctrl #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uCtrl (
    .opA(opA), .opB(opB), .ctrl(ctrl), .expGap(expGap)
  );

  fp18_add_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uDpath (
    .opA(opA), .opB(opB), .ctrl(ctrl), .expGap(expGap), .res(sumComb)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN) sum <= '0;
        else       sum <= sumComb;
      end
    end else begin : gComb
      assign sum = sumComb;
    end
  endgenerate

  // Checks written against the operand ports.
  logic             aNz, bNz;
  logic [EXP_W-1:0] eA, eB, portGap;
  assign aNz     = opA[MAN_W-1];
  assign bNz     = opB[MAN_W-1];
  assign eA      = opA[W-2:MAN_W];
  assign eB      = opB[W-2:MAN_W];
  assign portGap = (eA > eB) ? (eA - eB) : (eB - eA);

  assert_zero_pair_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!aNz && !bNz) |-> (sumComb == '0));

  assert_pass_other_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!aNz && bNz) |-> (sumComb == opB));

  assert_gap_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (aNz && bNz && portGap > EXP_W'(MAN_W - 1)) |-> (sumComb == opA || sumComb == opB));

  assert_like_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aNz && bNz && opA[W-1] == opB[W-1]) |-> (sumComb[W-1] == opA[W-1]));

  assert_normalized_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sumComb != '0) |-> sumComb[MAN_W-1]);

  assert_sub_exp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (aNz && bNz && opA[W-1] != opB[W-1] && sumComb != '0) |->
      (sumComb[W-2:MAN_W] <= ((eA > eB) ? eA : eB)));
endmodule

// File: tb/sim_fp18_adder.sv
module sim_fp18_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] opA = '0, opB = '0;
  logic [17:0] sum;
  int nVec = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fp18_adder u0 (.clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .sum(sum));

  function automatic real val(input logic [17:0] w);
    real mag;
    if (!w[8]) return 0.0;
    mag = real'(int'(w[8:0])) * (2.0 ** (real'(int'(w[16:9])) - 137.0));
    return w[17] ? -mag : mag;
  endfunction

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  // Real-number reference: the result lies on the larger operand's grid,
  // truncated for like signs and rounded up for unlike signs.
  function automatic logic [17:0] model(input logic [17:0] a, input logic [17:0] b);
    real va, vb, s, u, r;
    logic [17:0] big;
    int gap, e, q;
    if (!a[8] && !b[8]) return '0;
    if (!a[8]) return b;
    if (!b[8]) return a;
    va = val(a); vb = val(b);
    big = (rabs(va) >= rabs(vb)) ? a : b;
    gap = int'(a[16:9]) - int'(b[16:9]);
    if (gap < 0) gap = -gap;
    if (gap > 8) return big;
    s = va + vb;
    if (s == 0.0) return '0;
    e = int'(big[16:9]);
    u = 2.0 ** (real'(e) - 137.0);
    r = rabs(s) / u;
    q = (a[17] == b[17]) ? int'($floor(r)) : int'($ceil(r));
    while (q >= 512) begin q = q / 2; e++; end
    while (q < 256)  begin q = q * 2; e--; end
    return {(s < 0.0), 8'(e), 9'(q)};
  endfunction

  task automatic check(input logic [17:0] got, input logic [17:0] exp, input string tag,
                       input logic [17:0] a, input logic [17:0] b);
    nVec++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [17:0] a, input logic [17:0] b, input string tag);
    @(negedge clk);
    opA = a; opB = b;
    @(negedge clk);
    check(sum, model(a, b), tag, a, b);
  endtask

  initial begin
    logic [17:0] w0, w1;
    repeat (3) @(negedge clk);
    check(sum, 18'h0, "R8 reset", opA, opB);
    opA = {1'b0, 8'd130, 9'd300}; opB = {1'b0, 8'd129, 9'd400};
    @(negedge clk);
    check(sum, 18'h0, "R8 held in reset", opA, opB);
    rstN = 1'b1;

    // R1: zero words with nonzero other bits
    apply({1'b1, 8'h55, 9'h0AB}, {1'b0, 8'h3C, 9'h0FF}, "R1");
    // R2: one operand zero passes the other unchanged
    apply({1'b1, 8'h55, 9'h0AB}, {1'b1, 8'd131, 9'd333}, "R2");
    apply({1'b0, 8'd90, 9'd470}, {1'b0, 8'h77, 9'h011}, "R2");
    // R3: exponent tie decided by mantissa, sign of larger
    apply({1'b0, 8'd130, 9'd300}, {1'b1, 8'd130, 9'd301}, "R3");
    check(sum, {1'b1, 8'd122, 9'd256}, "R3 direct", opA, opB);
    // R7: exact cancellation
    apply({1'b0, 8'd140, 9'd377}, {1'b1, 8'd140, 9'd377}, "R7");
    check(sum, 18'h0, "R7 direct", opA, opB);
    // R6: deepest left shift (0.5 - 511/1024)
    apply({1'b0, 8'd128, 9'd256}, {1'b1, 8'd127, 9'd511}, "R6");
    check(sum, {1'b0, 8'd120, 9'd256}, "R6 direct", opA, opB);
    // R5/R10: carry out drops the low bit
    apply({1'b0, 8'd128, 9'd511}, {1'b0, 8'd128, 9'd511}, "R5");
    check(sum, {1'b0, 8'd129, 9'd511}, "R10 direct", opA, opB);
    // R4: gap of 9 bypasses
    apply({1'b1, 8'd140, 9'd300}, {1'b0, 8'd131, 9'd511}, "R4");
    check(sum, {1'b1, 8'd140, 9'd300}, "R4 direct", opA, opB);

    // R8: output holds until the clock edge
    w0 = {1'b0, 8'd129, 9'd256}; w1 = {1'b0, 8'd129, 9'd256};
    @(negedge clk); opA = w0; opB = w1;
    @(negedge clk);
    opA = {1'b1, 8'd129, 9'd256};
    #1 check(sum, {1'b0, 8'd130, 9'd256}, "R8 hold", w0, w1);
    @(negedge clk);
    check(sum, 18'h0, "R8 update", opA, w1);

    // Main sweep
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++)
        for (int d = -10; d <= 10; d++)
          for (int sg = 0; sg < 4; sg++) begin
            logic [17:0] a, b;
            string tag;
            a = {sg[0], 8'd130, 9'(256 + ia * 17)};
            b = {sg[1], 8'(130 + d), 9'(256 + ib * 17)};
            if (d > 8 || d < -8)      tag = "R4";
            else if (sg[0] == sg[1])  tag = "R5 R10";
            else                      tag = "R6 R9";
            apply(a, b, tag);
          end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nVec++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule